// File: doc/BRIEF.md
# Register-Configured Signal Routing Crossbar

This block is a static routing fabric between on-chip peripherals and twenty external pins. Each destination (a peripheral clock input, a peripheral data input, the data side of a pin buffer, or the output enable of a pin buffer) owns a 5-bit selector field. The code written into that field picks the source that drives the destination. Destinations and sources are split into three groups: clock, data and pin-enable. Each group has its own code table, and a destination can only select sources from its own group.

Software programs the fabric through a 32-bit word-addressed register bus. Six selector fields are packed into each register, lowest field in the lowest bits. Once a field is written, the selected source reaches the destination through combinational logic only. The block adds no latency and no protocol of its own.

The pin enable is an ordinary routable destination. It can follow a peripheral's direction output for bidirectional use. It can be tied to constant 0 or constant 1 for a fixed direction. It can also be driven by an unrelated signal, so that this signal gates the pin. A pin whose enable is low does not drive, and its input still reaches every group that takes pin inputs.

Top module: `sig_route_xbar`

## Requirements
- R1: After reset, every register reads 0 and every destination (periphClkIn, periphDatIn, padOut, padOutEn) is 0, whatever the sources are.
- R2: A register write stores bits 29:0 masked to its populated fields. Bits 31:30 and unpopulated fields read 0. Registers 10 and 14 populate only fields 0 and 1 (mask 0x3FF), and the others populate all six (mask 0x3FFFFFFF). Address 15 reads 0, and a write to it changes no register and no output.
- R3: Destination d of a group lives in register base+d/6, at bits [5*(d%6)+4 : 5*(d%6)]. The bases are 0 for clock (30 destinations, registers 0-4), 5 for data (32 destinations, registers 5-10) and 11 for pin-enable (20 destinations, registers 11-14).
- R4: In every group, code 0 drives constant 0 and code 1 drives constant 1.
- R5: Clock group: code 2+p selects padIn[p] (p=0..19), and code 22+k selects periphClkOut[k] (k=0..3). Codes 26-31 drive 0. Its destinations are periphClkIn[29:0].
- R6: Data group: codes 2-21 select padIn[0..19], codes 22-25 select periphClkOut[0..3], and codes 26-31 select periphDatOut[0..5]. Destinations 0-11 are periphDatIn[11:0], and destination 12+p is the data of pin p.
- R7: Pin-enable group: codes 2-7 select periphDirOut[0..5], codes 8-13 select periphDatOut[0..5], and codes 14-17 select periphClkOut[0..3]. Codes 18-31 drive 0. Destination p is the enable of pin p.
- R8: padOutEn[p] equals the routed enable of pin p. padOut[p] equals the routed data of pin p while the enable is 1, and is 0 while it is 0. padIn still feeds all groups regardless of the enable.
- R9: A write takes effect on the clock edge that samples it: destinations keep their old selection before that edge and use the new one after it. A source change reaches its destination in the same cycle, without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register word address |
| busWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| periphClkOut | input | 4 | Clock outputs of the peripherals |
| periphDatOut | input | 6 | Data outputs of the peripherals |
| periphDirOut | input | 6 | Direction (drive request) outputs of the peripherals |
| periphClkIn | output | 30 | Routed peripheral clock inputs |
| periphDatIn | output | 12 | Routed peripheral data inputs |
| padIn | input | 20 | Sensed level of each external pin |
| padOut | output | 20 | Value driven onto each pin |
| padOutEn | output | 20 | Drive enable of each pin buffer |

## Verification
The embedded properties take for granted that busAddr, busWrEn and busWrData are known and steady around each rising edge, and that reset is asserted before the first edge. Under those conditions, the properties can tie a decoded write strobe to the register it must update, and the absence of a strobe to a register that must hold. They also assume that a pin reported as not driving never shows a driven 1. The stimulus changes every bus and source input only at the falling clock edge, and it holds reset low across several edges at the start. In the one check for same-cycle response, a source is moved between edges and no write is pending at that time.

// File: rtl/route_pkg.sv
package route_pkg;

  // Field and bus geometry
  parameter int FW       = 5;
  parameter int FPR      = 6;
  parameter int REG_W    = FW * FPR;
  parameter int BUS_W    = 32;

  // Pin and peripheral counts
  parameter int NUM_PINS = 20;
  parameter int CLK_OUT  = 4;
  parameter int DAT_OUT  = 6;
  parameter int DIR_OUT  = 6;
  parameter int CLK_IN   = 30;
  parameter int DAT_IN   = 12;

  // Destinations per group
  parameter int CLK_DST  = CLK_IN;
  parameter int DAT_DST  = DAT_IN + NUM_PINS;
  parameter int ENA_DST  = NUM_PINS;

  // Sources per group (codes 0 and 1 are the constants)
  parameter int CLK_SRC  = NUM_PINS + CLK_OUT;
  parameter int DAT_SRC  = NUM_PINS + CLK_OUT + DAT_OUT;
  parameter int ENA_SRC  = DIR_OUT + DAT_OUT + CLK_OUT;

  // Register map
  parameter int CLK_REGS = (CLK_DST + FPR - 1) / FPR;
  parameter int DAT_REGS = (DAT_DST + FPR - 1) / FPR;
  parameter int ENA_REGS = (ENA_DST + FPR - 1) / FPR;
  parameter int CLK_BASE = 0;
  parameter int DAT_BASE = CLK_BASE + CLK_REGS;
  parameter int ENA_BASE = DAT_BASE + DAT_REGS;
  parameter int NUM_REGS = ENA_BASE + ENA_REGS;
  parameter int ADDR_W   = $clog2(NUM_REGS + 1);

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_REGS-1:0] wr;
    logic                rdHit;
    logic [ADDR_W-1:0]   rdIdx;
  } rtStrobe_t;

  // Bits of register r that hold populated fields
  function automatic logic [REG_W-1:0] regMask(input int r);
    int nFld;
    logic [REG_W-1:0] m;
    if (r < DAT_BASE)      nFld = CLK_DST - (r - CLK_BASE) * FPR;
    else if (r < ENA_BASE) nFld = DAT_DST - (r - DAT_BASE) * FPR;
    else                   nFld = ENA_DST - (r - ENA_BASE) * FPR;
    m = '0;
    for (int f = 0; f < FPR; f++) begin
      if (f < nFld) m[f*FW +: FW] = '1;
    end
    return m;
  endfunction

endpackage

// File: rtl/route_ctrl.sv
module route_ctrl
  import route_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output rtStrobe_t         strb
);

  always_comb begin
    strb       = '0;
    strb.rdIdx = busAddr;
    if (int'(busAddr) < NUM_REGS) begin
      strb.rdHit        = 1'b1;
      strb.wr[busAddr]  = busWrEn;
    end
  end

  // R2: at most one register is written per cycle
  a_r2_single_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.wr));

  // R2: an unmapped address never raises a write strobe
  a_r2_unmapped_nowrite: assert property (@(posedge clk) disable iff (!rstN)
    (int'(busAddr) >= NUM_REGS) |-> (strb.wr == '0));

endmodule

// File: rtl/route_group_mux.sv
module route_group_mux #(
  parameter int NUM_DST = 1,
  parameter int NUM_SRC = 1,
  parameter int SEL_W   = 5
) (
  input  logic [NUM_DST-1:0][SEL_W-1:0] sel,
  input  logic [NUM_SRC-1:0]            src,
  output logic [NUM_DST-1:0]            dst
);

  localparam int CODES    = 1 << SEL_W;
  localparam int SRC_BASE = 2;

  // Code table: 0 -> low, 1 -> high, then sources, rest low
  logic [CODES-1:0] codeTbl;

  always_comb begin
    codeTbl                      = '0;
    codeTbl[1]                   = 1'b1;
    codeTbl[SRC_BASE +: NUM_SRC] = src;
  end

  for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
    assign dst[d] = codeTbl[sel[d]];
  end

endmodule

// File: rtl/route_pad_buf.sv
module route_pad_buf #(
  parameter int NUM_PADS = 20
) (
  input  logic [NUM_PADS-1:0] padData,
  input  logic [NUM_PADS-1:0] padEna,
  output logic [NUM_PADS-1:0] padOut,
  output logic [NUM_PADS-1:0] padOutEn
);

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    assign padOutEn[p] = padEna[p];
    assign padOut[p]   = padEna[p] ? padData[p] : 1'b0;
  end

endmodule

// File: rtl/route_dp.sv
module route_dp
  import route_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  rtStrobe_t           strb,
  input  logic [BUS_W-1:0]    busWrData,
  output logic [BUS_W-1:0]    busRdData,
  input  logic [CLK_OUT-1:0]  periphClkOut,
  input  logic [DAT_OUT-1:0]  periphDatOut,
  input  logic [DIR_OUT-1:0]  periphDirOut,
  output logic [CLK_IN-1:0]   periphClkIn,
  output logic [DAT_IN-1:0]   periphDatIn,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOutEn
);

  logic [REG_W-1:0] regQ [NUM_REGS];
  logic             unusedWrHi;

  assign unusedWrHi = ^busWrData[BUS_W-1:REG_W];

  // Register file
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [REG_W-1:0] FLD_MASK = regMask(i);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          regQ[i] <= '0;
      else if (strb.wr[i]) regQ[i] <= busWrData[REG_W-1:0] & FLD_MASK;
    end

    // R9: a strobed write lands on the next edge
    a_r9_write_lands: assert property (@(posedge clk) disable iff (!rstN)
      strb.wr[i] |=> (regQ[i] == ($past(busWrData[REG_W-1:0]) & FLD_MASK)));

    // R9: without a strobe the register holds
    a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
      !strb.wr[i] |=> $stable(regQ[i]));

    // R2: unpopulated bits stay clear
    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
      (regQ[i] & ~FLD_MASK) == '0);
  end

  // Read mux
  always_comb begin
    busRdData = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (strb.rdHit && (strb.rdIdx == ADDR_W'(i)))
        busRdData = {{(BUS_W-REG_W){1'b0}}, regQ[i]};
    end
  end

  // Field extraction per group
  logic [CLK_DST-1:0][FW-1:0] clkSel;
  logic [DAT_DST-1:0][FW-1:0] datSel;
  logic [ENA_DST-1:0][FW-1:0] enaSel;

  for (genvar d = 0; d < CLK_DST; d++) begin : g_clkFld
    assign clkSel[d] = regQ[CLK_BASE + d/FPR][(d%FPR)*FW +: FW];
  end
  for (genvar d = 0; d < DAT_DST; d++) begin : g_datFld
    assign datSel[d] = regQ[DAT_BASE + d/FPR][(d%FPR)*FW +: FW];
  end
  for (genvar d = 0; d < ENA_DST; d++) begin : g_enaFld
    assign enaSel[d] = regQ[ENA_BASE + d/FPR][(d%FPR)*FW +: FW];
  end

  // Source vectors, lowest bit is code 2
  logic [CLK_SRC-1:0] clkSrc;
  logic [DAT_SRC-1:0] datSrc;
  logic [ENA_SRC-1:0] enaSrc;

  assign clkSrc = {periphClkOut, padIn};
  assign datSrc = {periphDatOut, periphClkOut, padIn};
  assign enaSrc = {periphClkOut, periphDatOut, periphDirOut};

  logic [DAT_DST-1:0] datDst;
  logic [ENA_DST-1:0] enaDst;

  route_group_mux #(.NUM_DST(CLK_DST), .NUM_SRC(CLK_SRC), .SEL_W(FW)) i_clkMux (
    .sel (clkSel),
    .src (clkSrc),
    .dst (periphClkIn)
  );

  route_group_mux #(.NUM_DST(DAT_DST), .NUM_SRC(DAT_SRC), .SEL_W(FW)) i_datMux (
    .sel (datSel),
    .src (datSrc),
    .dst (datDst)
  );

  route_group_mux #(.NUM_DST(ENA_DST), .NUM_SRC(ENA_SRC), .SEL_W(FW)) i_enaMux (
    .sel (enaSel),
    .src (enaSrc),
    .dst (enaDst)
  );

  assign periphDatIn = datDst[DAT_IN-1:0];

  route_pad_buf #(.NUM_PADS(NUM_PINS)) i_padBuf (
    .padData  (datDst[DAT_DST-1:DAT_IN]),
    .padEna   (enaDst),
    .padOut   (padOut),
    .padOutEn (padOutEn)
  );

  // R8: a pin that is not driving shows no driven one
  a_r8_pad_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (padOut & ~padOutEn) == '0);

  // R1: all destinations are low on the first cycle after reset
  a_r1_reset_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> ((periphClkIn == '0) && (periphDatIn == '0) && (padOutEn == '0)));

endmodule

// File: rtl/sig_route_xbar.sv
module sig_route_xbar
  import route_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [BUS_W-1:0]    busWrData,
  output logic [BUS_W-1:0]    busRdData,
  input  logic [CLK_OUT-1:0]  periphClkOut,
  input  logic [DAT_OUT-1:0]  periphDatOut,
  input  logic [DIR_OUT-1:0]  periphDirOut,
  output logic [CLK_IN-1:0]   periphClkIn,
  output logic [DAT_IN-1:0]   periphDatIn,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOutEn
);

  rtStrobe_t strb;

  route_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strb    (strb)
  );

  route_dp i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .busWrData    (busWrData),
    .busRdData    (busRdData),
    .periphClkOut (periphClkOut),
    .periphDatOut (periphDatOut),
    .periphDirOut (periphDirOut),
    .periphClkIn  (periphClkIn),
    .periphDatIn  (periphDatIn),
    .padIn        (padIn),
    .padOut       (padOut),
    .padOutEn     (padOutEn)
  );

endmodule

// File: tb/test_sig_route_xbar.sv
`timescale 1ns/1ps
module test_sig_route_xbar;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [3:0]  periphClkOut = '0;
  logic [5:0]  periphDatOut = '0;
  logic [5:0]  periphDirOut = '0;
  logic [29:0] periphClkIn;
  logic [11:0] periphDatIn;
  logic [19:0] padIn = '0;
  logic [19:0] padOut;
  logic [19:0] padOutEn;

  always #5 clk = ~clk;

  sig_route_xbar i_sig_route_xbar (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .periphClkOut(periphClkOut), .periphDatOut(periphDatOut),
    .periphDirOut(periphDirOut), .periphClkIn(periphClkIn),
    .periphDatIn(periphDatIn), .padIn(padIn), .padOut(padOut),
    .padOutEn(padOutEn)
  );

  int checks = 0;
  int failures = 0;
  logic [31:0] shadow [15];

  typedef struct packed {
    logic [3:0]  addr;
    logic [31:0] data;
    logic [3:0]  cOut;
    logic [5:0]  dOut;
    logic [5:0]  rOut;
    logic [19:0] pad;
    logic [1:0]  kind;   // 0 clkIn, 1 datIn, 2 padOut, 3 padOutEn
    logic [4:0]  idx;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{4'd0,  32'h00000001, 4'h0, 6'h00, 6'h00, 20'h00000, 2'd0, 5'd0,  1'b1, 4'd4}, // R4 const1
    '{4'd1,  32'h00000020, 4'h0, 6'h00, 6'h00, 20'h00000, 2'd0, 5'd7,  1'b1, 4'd4}, // R4 field1
    '{4'd4,  32'h2A000000, 4'h0, 6'h00, 6'h00, 20'h80000, 2'd0, 5'd29, 1'b1, 4'd5}, // R5 pad19, R8 input while idle
    '{4'd4,  32'h2A000000, 4'h0, 6'h00, 6'h00, 20'h00000, 2'd0, 5'd29, 1'b0, 4'd5}, // R5 pad19 low
    '{4'd2,  32'h00000019, 4'h8, 6'h00, 6'h00, 20'h00000, 2'd0, 5'd12, 1'b1, 4'd5}, // R5 clkOut3
    '{4'd2,  32'h0000001A, 4'hF, 6'h3F, 6'h3F, 20'hFFFFF, 2'd0, 5'd12, 1'b0, 4'd5}, // R5 undefined code
    '{4'd5,  32'h000F8000, 4'h0, 6'h20, 6'h00, 20'h00000, 2'd1, 5'd3,  1'b1, 4'd6}, // R6 datOut5
    '{4'd6,  32'h12000000, 4'h0, 6'h00, 6'h00, 20'h00080, 2'd1, 5'd11, 1'b1, 4'd6}, // R6 pad7
    '{4'd7,  32'h01700000, 4'h2, 6'h00, 6'h00, 20'h00000, 2'd2, 5'd4,  1'b0, 4'd8}, // R8 data set, enable low
    '{4'd11, 32'h00400000, 4'h2, 6'h00, 6'h04, 20'h00000, 2'd3, 5'd4,  1'b1, 4'd7}, // R7 dir2
    '{4'd11, 32'h00400000, 4'h2, 6'h00, 6'h04, 20'h00000, 2'd2, 5'd4,  1'b1, 4'd8}, // R8 drives data
    '{4'd11, 32'h00400000, 4'h2, 6'h00, 6'h00, 20'h00000, 2'd3, 5'd4,  1'b0, 4'd7}, // R7 dir2 low
    '{4'd11, 32'h00800000, 4'h2, 6'h01, 6'h00, 20'h00000, 2'd2, 5'd4,  1'b1, 4'd7}, // R7 gated by datOut0
    '{4'd11, 32'h00800000, 4'h0, 6'h01, 6'h00, 20'h00000, 2'd2, 5'd4,  1'b0, 4'd6}, // R6 clkOut1 data low
    '{4'd11, 32'h01100000, 4'h8, 6'h00, 6'h00, 20'h00000, 2'd3, 5'd4,  1'b1, 4'd7}, // R7 clkOut3
    '{4'd11, 32'h01200000, 4'hF, 6'h3F, 6'h3F, 20'hFFFFF, 2'd3, 5'd4,  1'b0, 4'd7}, // R7 undefined code
    '{4'd5,  32'h00000016, 4'h1, 6'h00, 6'h00, 20'h00000, 2'd1, 5'd0,  1'b1, 4'd6}  // R6 clkOut0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] maskOf(input int a);
    if (a == 10 || a == 14) return 32'h000003FF;
    else if (a < 15)        return 32'h3FFFFFFF;
    else                    return 32'h0;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    if (int'(a) < 15) shadow[a] = d & maskOf(int'(a));
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  function automatic logic obs(input logic [1:0] kind, input int idx);
    case (kind)
      2'd0:    return periphClkIn[idx];
      2'd1:    return periphDatIn[idx];
      2'd2:    return padOut[idx];
      default: return padOutEn[idx];
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    logic [29:0] clkSnap;
    for (int i = 0; i < 15; i++) shadow[i] = '0;
    periphClkOut = '1; periphDatOut = '1; periphDirOut = '1; padIn = '1;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state with all sources high
    #1;
    chk("R1 clkIn", {2'b0, periphClkIn}, 32'h0);
    chk("R1 datIn", {20'b0, periphDatIn}, 32'h0);
    chk("R1 padOut", {12'b0, padOut}, 32'h0);
    chk("R1 padOutEn", {12'b0, padOutEn}, 32'h0);
    for (int a = 0; a < 15; a++) begin
      rd(4'(a), rv);
      chk("R1 regRead", rv, 32'h0);
    end
    periphClkOut = '0; periphDatOut = '0; periphDirOut = '0; padIn = '0;

    // R2: masked readback
    wr(4'd3, 32'hFFFFFFFF);  rd(4'd3, rv);  chk("R2 full reg", rv, 32'h3FFFFFFF);
    wr(4'd10, 32'hFFFFFFFF); rd(4'd10, rv); chk("R2 partial reg10", rv, 32'h000003FF);
    wr(4'd14, 32'hFFFFFFFF); rd(4'd14, rv); chk("R2 partial reg14", rv, 32'h000003FF);
    wr(4'd3, 32'h0); wr(4'd10, 32'h0); wr(4'd14, 32'h0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      periphClkOut = VEC[v].cOut; periphDatOut = VEC[v].dOut;
      periphDirOut = VEC[v].rOut; padIn = VEC[v].pad;
      wr(VEC[v].addr, VEC[v].data);
      #1;
      chk($sformatf("R%0d vec%0d", VEC[v].req, v),
          {31'b0, obs(VEC[v].kind, int'(VEC[v].idx))}, {31'b0, VEC[v].exp});
    end

    // R3: field 5 of register 0 is clock destination 5
    periphClkOut = '0; periphDatOut = '0; periphDirOut = '0; padIn = '0;
    wr(4'd0, 32'h02000000);
    #1 chk("R3 packing clkIn[5:0]", {26'b0, periphClkIn[5:0]}, 32'h20);
    rd(4'd0, rv); chk("R3 readback", rv, 32'h02000000);

    // R2: unmapped address ignored
    clkSnap = periphClkIn;
    wr(4'd15, 32'hFFFFFFFF);
    #1 chk("R2 unmapped no effect", {2'b0, periphClkIn}, {2'b0, clkSnap});
    rd(4'd15, rv); chk("R2 unmapped read", rv, 32'h0);
    for (int a = 0; a < 15; a++) begin
      rd(4'(a), rv);
      chk("R2 shadow compare", rv, shadow[a]);
    end

    // R9: write effective only after its edge
    @(negedge clk);
    busAddr = 4'd1; busWrData = 32'h00000021; busWrEn = 1'b1;
    #1 chk("R9 before edge", {31'b0, periphClkIn[6]}, 32'h0);
    @(negedge clk);
    busWrEn = 1'b0; shadow[1] = 32'h21;
    #1 chk("R9 after edge", {31'b0, periphClkIn[6]}, 32'h1);

    // R9: source change reaches destination without an edge
    wr(4'd2, 32'h00000019);
    #1 chk("R9 src low", {31'b0, periphClkIn[12]}, 32'h0);
    periphClkOut = 4'h8;
    #1 chk("R9 same-cycle src", {31'b0, periphClkIn[12]}, 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule